// File: doc/BRIEF.md
# Criticality-Aware Memory Request Scheduler

This block sits in front of a DRAM controller and is shared by many GPU cores. It holds a small buffer of pending memory requests and, every cycle, names the buffered request that should be issued next. Each core reports two warp counts: how many of its warps are active, and how many of those are stalled on outstanding DRAM data. A core whose stalled share reaches a programmable level counts as latency-intolerant, or "critical". Every buffered request takes on the current status of the core that sent it, and that status is worked out again every cycle.

The scheduler has two orderings. In the first, critical requests come first. In the second, requests that hit a bank's open row come first. It picks the ordering by comparing the share of critical requests in the buffer with a programmable threshold. While critical requests are scarce, serving them early helps the cores that are waiting. Once they are common, giving some of them priority over others gains little, so row locality decides instead. The downstream controller takes the named request by raising `deq_ready`. The block then frees that slot and records the request's row as the open row of its bank.

Top module: `crit_sched`

## Requirements
- R1: After a synchronous active-low reset the buffer is empty, `grant_valid` and `buf_full` are low, and every bank's open row is closed, so no request counts as a row hit until one request has been issued to that bank.
- R2: An enqueue (`enq_valid` high at a rising edge) writes into the lowest-numbered free slot. `buf_full` is high exactly when all 16 slots are occupied. An enqueue while `buf_full` is high is dropped, even if an issue frees a slot at the same edge.
- R3: A core c counts as critical when stalled_c × 4 ≥ active_c × `crit_num`. `crit_num` is read as a plain unsigned number, so 0 makes every core critical. Each buffered request is critical exactly when its core is critical in the current cycle.
- R4: The criticality-first ordering is in force when critical_count × 16 < `crit_thresh` × valid_count. Otherwise (fraction at or above threshold/16) the locality-first ordering is used.
- R5: Under criticality-first ordering with at least one critical request present, the grant is a critical request. Among the critical requests a row hit wins, and among equals the oldest wins.
- R6: Under locality-first ordering, or when no request is critical, criticality is ignored: a row hit wins, and among equals the oldest wins.
- R7: `grant_valid` is high exactly when the buffer holds at least one request. `grant_idx` always names an occupied slot. When `grant_valid` and `deq_ready` are both high at a rising edge, that slot is freed.
- R8: On an issue, the open row of the issued request's bank becomes that request's row. A request counts as a row hit when its bank has an open row equal to its own row.
- R9: Age is the order of enqueue among the requests currently buffered. It does not depend on slot number, so a request placed in a low slot after older requests is younger than them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enq_valid | input | 1 | Enqueue a request this cycle |
| enq_core | input | 4 | Originating core of the request |
| enq_bank | input | 3 | Target DRAM bank |
| enq_row | input | 12 | Target DRAM row |
| stall_warps | input | 96 | Per-core stalled-warp counts, 6 bits per core, core c at bits [6c+5:6c] |
| active_warps | input | 96 | Per-core active-warp counts, same packing |
| crit_num | input | 3 | Criticality numerator (0 to 4 intended) |
| crit_thresh | input | 5 | Critical-share threshold in sixteenths (0 to 16) |
| deq_ready | input | 1 | Controller accepts the granted request at this edge |
| grant_valid | output | 1 | A request is granted this cycle |
| grant_idx | output | 4 | Slot index of the granted request |
| buf_full | output | 1 | All slots occupied |

## Verification
The grant outputs are combinational in the registered buffer and the live warp-count inputs. A change to the counts, the numerator or the threshold therefore shows up in `grant_valid`/`grant_idx` in the same cycle. An enqueue or issue shows up only after the next rising edge, and so does the open-row update that turns later requests into hits. The bench applies every input at the falling edge, samples the outputs 2 ns later (well before the next rising edge), and advances its own arithmetic model of buffer, age order and open rows at the rising edge. Each comparison therefore sees exactly the state the design holds in that cycle.

// File: rtl/crit_sched_pkg.sv
// Shared definitions for the criticality-aware request scheduler.
// Assumes nothing beyond standard SystemVerilog packed types.
package crit_sched_pkg;
    // Arbitration ordering currently in force.
    typedef enum logic {
        ORDER_LOCALITY = 1'b0,
        ORDER_CRITICAL = 1'b1
    } order_e;
endpackage

// File: rtl/crit_core_class.sv
// Classifies each core as latency-critical from its warp counts.
// Core c is critical when stall*4 >= active*num; purely combinational.
// Assumes counts arrive packed WARP_W bits per core, core 0 lowest.
module crit_core_class #(
    parameter int CORES  = 16,
    parameter int WARP_W = 6,
    parameter int NUM_W  = 3
) (
    input  logic [CORES*WARP_W-1:0] stall_warps,
    input  logic [CORES*WARP_W-1:0] active_warps,
    input  logic [NUM_W-1:0]        crit_num,
    output logic [CORES-1:0]        core_crit
);
    localparam int CMP_W = WARP_W + NUM_W + 2;

    for (genvar c = 0; c < CORES; c++) begin : g_core
        logic [CMP_W-1:0] lhs, rhs;
        // Scaled stalled share against the programmable fraction.
        always_comb begin
            lhs = CMP_W'(stall_warps[c*WARP_W +: WARP_W]) << 2;
            rhs = CMP_W'(active_warps[c*WARP_W +: WARP_W]) * CMP_W'(crit_num);
            core_crit[c] = (lhs >= rhs);
        end
    end
endmodule

// File: rtl/crit_age_matrix.sv
// Tracks relative enqueue order of buffer slots as an age matrix.
// older[i][j] = 1 means slot i was enqueued before slot j. Entries for
// free slots are stale and must be masked with the valid vector.
// Assumes at most one allocation per cycle.
module crit_age_matrix #(
    parameter int DEPTH = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        alloc_en,
    input  logic [DEPTH-1:0]            alloc_oh,
    input  logic [DEPTH-1:0]            valid_q,
    output logic [DEPTH-1:0][DEPTH-1:0] older
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        for (genvar j = 0; j < DEPTH; j++) begin : g_col
            if (i == j) begin : g_diag
                assign older[i][j] = 1'b0;
            end else begin : g_cell
                // Newly written slot is younger than every occupied slot.
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        older[i][j] <= 1'b0;
                    else if (alloc_en && alloc_oh[j])
                        older[i][j] <= valid_q[i];
                    else if (alloc_en && alloc_oh[i])
                        older[i][j] <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/crit_pick.sv
// Chooses the ordering from the critical share and picks one slot:
// optional critical filter, then row-hit filter, then oldest.
// Assumes the age matrix is a strict order over valid slots.
module crit_pick
    import crit_sched_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int THR_W = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0]             valid,
    input  logic [DEPTH-1:0]             crit,
    input  logic [DEPTH-1:0]             hit,
    input  logic [DEPTH-1:0][DEPTH-1:0]  older,
    input  logic [THR_W-1:0]             thresh,
    output logic                         grant_valid,
    output logic [$clog2(DEPTH)-1:0]     grant_idx
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int PROD_W = CNT_W + THR_W + 1;
    localparam int SCALE  = 2 ** (THR_W - 1);

    logic [CNT_W-1:0] crit_cnt, val_cnt;
    order_e           order;
    logic [DEPTH-1:0] crit_live, stage1, hit_mask, stage2, oldest;

    // Count occupied and critical slots.
    always_comb begin
        crit_cnt = '0;
        val_cnt  = '0;
        for (int i = 0; i < DEPTH; i++) begin
            val_cnt  = val_cnt + CNT_W'(valid[i]);
            crit_cnt = crit_cnt + CNT_W'(valid[i] & crit[i]);
        end
    end

    // Division-free compare of critical share against threshold.
    always_comb begin
        if (PROD_W'(crit_cnt) * PROD_W'(SCALE) < PROD_W'(thresh) * PROD_W'(val_cnt))
            order = ORDER_CRITICAL;
        else
            order = ORDER_LOCALITY;
    end

    // Narrow the candidate set class by class.
    always_comb begin
        crit_live = valid & crit;
        stage1    = (order == ORDER_CRITICAL && |crit_live) ? crit_live : valid;
        hit_mask  = stage1 & hit;
        stage2    = (|hit_mask) ? hit_mask : stage1;
    end

    // Oldest candidate: no other candidate is older than it.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            oldest[i] = stage2[i];
            for (int j = 0; j < DEPTH; j++)
                if (stage2[j] && older[j][i])
                    oldest[i] = 1'b0;
        end
    end

    // One-hot to index encode.
    always_comb begin
        grant_idx = '0;
        for (int i = 0; i < DEPTH; i++)
            if (oldest[i])
                grant_idx = grant_idx | IDX_W'(i);
        grant_valid = |oldest;
    end

    assert_single_oldest_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(oldest));
    assert_grant_iff_occupied_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid == (|valid));
    assert_critical_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (order == ORDER_CRITICAL && |(valid & crit)) |-> crit[grant_idx]);
    assert_hit_preferred_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (order == ORDER_LOCALITY && |(valid & hit)) |-> hit[grant_idx]);
endmodule

// File: rtl/crit_sched.sv
// Top of the criticality-aware memory request scheduler. Holds the
// request buffer and per-bank open rows, derives per-slot critical and
// row-hit flags, and names the request to issue next.
// Assumes BANKS and CORES are powers of two matching their ID widths.
module crit_sched #(
    parameter int DEPTH  = 16,
    parameter int CORES  = 16,
    parameter int BANKS  = 8,
    parameter int ROW_W  = 12,
    parameter int WARP_W = 6,
    parameter int NUM_W  = 3,
    parameter int THR_W  = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       enq_valid,
    input  logic [$clog2(CORES)-1:0]   enq_core,
    input  logic [$clog2(BANKS)-1:0]   enq_bank,
    input  logic [ROW_W-1:0]           enq_row,
    input  logic [CORES*WARP_W-1:0]    stall_warps,
    input  logic [CORES*WARP_W-1:0]    active_warps,
    input  logic [NUM_W-1:0]           crit_num,
    input  logic [THR_W-1:0]           crit_thresh,
    input  logic                       deq_ready,
    output logic                       grant_valid,
    output logic [$clog2(DEPTH)-1:0]   grant_idx,
    output logic                       buf_full
);
    localparam int IDX_W  = $clog2(DEPTH);
    localparam int CORE_W = $clog2(CORES);
    localparam int BANK_W = $clog2(BANKS);

    logic [DEPTH-1:0]             valid_q;
    logic [CORE_W-1:0]            core_q [DEPTH];
    logic [BANK_W-1:0]            bank_q [DEPTH];
    logic [ROW_W-1:0]             row_q  [DEPTH];
    logic [ROW_W-1:0]             open_row_q [BANKS];
    logic [BANKS-1:0]             open_vld_q;

    logic [CORES-1:0]             core_crit;
    logic [DEPTH-1:0]             slot_crit, slot_hit, alloc_oh;
    logic [DEPTH-1:0][DEPTH-1:0]  older;
    logic [IDX_W-1:0]             free_idx;
    logic                         alloc_en, issue;
    logic [BANK_W-1:0]            issue_bank;
    logic [ROW_W-1:0]             issue_row;

    crit_core_class #(.CORES(CORES), .WARP_W(WARP_W), .NUM_W(NUM_W)) u_class (
        .stall_warps (stall_warps),
        .active_warps(active_warps),
        .crit_num    (crit_num),
        .core_crit   (core_crit)
    );

    // Per-slot criticality inherited from the core, and row-hit status.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slot_crit[i] = core_crit[core_q[i]];
            slot_hit[i]  = open_vld_q[bank_q[i]] && (open_row_q[bank_q[i]] == row_q[i]);
        end
    end

    // Lowest free slot and enqueue acceptance.
    always_comb begin
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!valid_q[i])
                free_idx = IDX_W'(i);
        buf_full = &valid_q;
        alloc_en = enq_valid && !buf_full;
        alloc_oh = alloc_en ? (DEPTH'(1) << free_idx) : '0;
    end

    crit_age_matrix #(.DEPTH(DEPTH)) u_age (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc_en(alloc_en),
        .alloc_oh(alloc_oh),
        .valid_q (valid_q),
        .older   (older)
    );

    crit_pick #(.DEPTH(DEPTH), .THR_W(THR_W)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (valid_q),
        .crit       (slot_crit),
        .hit        (slot_hit),
        .older      (older),
        .thresh     (crit_thresh),
        .grant_valid(grant_valid),
        .grant_idx  (grant_idx)
    );

    // Issue handshake and the issued request's location.
    always_comb begin
        issue      = grant_valid && deq_ready;
        issue_bank = bank_q[grant_idx];
        issue_row  = row_q[grant_idx];
    end

    // Occupancy: clear the issued slot, set the allocated slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else begin
            if (issue)
                valid_q[grant_idx] <= 1'b0;
            if (alloc_en)
                valid_q[free_idx] <= 1'b1;
        end
    end

    // Request payload capture; payload of free slots is never used.
    always_ff @(posedge clk) begin
        if (alloc_en) begin
            core_q[free_idx] <= enq_core;
            bank_q[free_idx] <= enq_bank;
            row_q[free_idx]  <= enq_row;
        end
    end

    // Open-row tracking per bank, updated by issued requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_vld_q <= '0;
        end else if (issue) begin
            open_vld_q[issue_bank] <= 1'b1;
            open_row_q[issue_bank] <= issue_row;
        end
    end

    assert_grant_occupied_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> valid_q[grant_idx]);
    assert_issue_frees_R7: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !valid_q[$past(grant_idx)]);
    assert_alloc_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |=> valid_q[$past(free_idx)]);
    assert_full_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_full && !issue) |=> $stable(valid_q));
    assert_open_row_R8: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (open_vld_q[$past(issue_bank)] && open_row_q[$past(issue_bank)] == $past(issue_row)));
endmodule

// File: tb/crit_sched_test.sv
// Self-checking bench: directed sweeps plus a long model-based sweep.
module crit_sched_test;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int D = 16, C = 16, B = 8, RW = 12, WW = 6;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             enq_valid, deq_ready;
    logic [3:0]       enq_core;
    logic [2:0]       enq_bank;
    logic [RW-1:0]    enq_row;
    logic [C*WW-1:0]  stall_warps, active_warps;
    logic [2:0]       crit_num;
    logic [4:0]       crit_thresh;
    logic             grant_valid, buf_full;
    logic [3:0]       grant_idx;

    crit_sched uut (
        .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_core(enq_core),
        .enq_bank(enq_bank), .enq_row(enq_row), .stall_warps(stall_warps),
        .active_warps(active_warps), .crit_num(crit_num), .crit_thresh(crit_thresh),
        .deq_ready(deq_ready), .grant_valid(grant_valid), .grant_idx(grant_idx),
        .buf_full(buf_full)
    );

    always #10 clk = ~clk;

    int checks = 0, failures = 0;
    bit m_val [D];
    int m_core [D], m_bank [D], m_row [D], m_seq [D];
    int m_open [B];
    bit m_open_v [B];
    int seq_ctr = 0;
    int stl [C], act [C];
    int num = 0, thr = 0;
    int last_idx = 0;

    task automatic check(bit ok, string tag, int actual, int expected);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    function automatic bit core_is_crit(int c);
        return stl[c] * 4 >= act[c] * num;
    endfunction

    // Expected grant per the ordering rules; -1 when empty.
    function automatic int model_pick(output string tag);
        int cc = 0, vc = 0, best = -1, bkey = -1, bseq = 0;
        bit use_crit;
        for (int i = 0; i < D; i++)
            if (m_val[i]) begin
                vc++;
                if (core_is_crit(m_core[i])) cc++;
            end
        use_crit = (cc * 16 < thr * vc) && (cc > 0);
        for (int i = 0; i < D; i++)
            if (m_val[i]) begin
                int key;
                key = (use_crit && core_is_crit(m_core[i])) ? 2 : 0;
                if (m_open_v[m_bank[i]] && m_open[m_bank[i]] == m_row[i]) key += 1;
                if (key > bkey || (key == bkey && m_seq[i] < bseq)) begin
                    best = i; bkey = key; bseq = m_seq[i];
                end
            end
        tag = (vc == 0) ? "R7" : (use_crit ? "R5" : "R6");
        return best;
    endfunction

    function automatic int model_count();
        int n = 0;
        for (int i = 0; i < D; i++) n += int'(m_val[i]);
        return n;
    endfunction

    task automatic drive_static();
        for (int c = 0; c < C; c++) begin
            stall_warps[c*WW +: WW]  = WW'(stl[c]);
            active_warps[c*WW +: WW] = WW'(act[c]);
        end
        crit_num    = 3'(num);
        crit_thresh = 5'(thr);
    endtask

    // One cycle: drive at falling edge, check, advance model at rising edge.
    task automatic step(bit enq, int core, int bank, int row, bit deq);
        int e, cnt;
        string tag;
        @(negedge clk);
        enq_valid = enq; enq_core = 4'(core); enq_bank = 3'(bank);
        enq_row = RW'(row); deq_ready = deq;
        drive_static();
        #2;
        e = model_pick(tag);
        cnt = model_count();
        check(grant_valid == (e >= 0), "R7", int'(grant_valid), int'(e >= 0));
        if (e >= 0) check(int'(grant_idx) == e, tag, int'(grant_idx), e);
        check(buf_full == (cnt == D), "R2", int'(buf_full), int'(cnt == D));
        last_idx = int'(grant_idx);
        @(posedge clk);
        if (enq && cnt < D) begin
            int f = -1;
            for (int i = D - 1; i >= 0; i--) if (!m_val[i]) f = i;
            if (deq && e >= 0) begin
                m_val[e] = 1'b0;
                m_open[m_bank[e]] = m_row[e]; m_open_v[m_bank[e]] = 1'b1;
            end
            m_val[f] = 1'b1; m_core[f] = core; m_bank[f] = bank;
            m_row[f] = row; m_seq[f] = seq_ctr++;
        end else if (deq && e >= 0) begin
            m_val[e] = 1'b0;
            m_open[m_bank[e]] = m_row[e]; m_open_v[m_bank[e]] = 1'b1;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; enq_valid = 1'b0; deq_ready = 1'b0;
        enq_core = '0; enq_bank = '0; enq_row = '0;
        drive_static();
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < D; i++) m_val[i] = 1'b0;
        for (int b = 0; b < B; b++) m_open_v[b] = 1'b0;
    endtask

    task automatic idle_all();
        for (int c = 0; c < C; c++) begin stl[c] = 0; act[c] = 8; end
    endtask

    initial begin
        #(20.0 * 200000);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle_all(); num = 2; thr = 8;
        do_reset();
        #2;
        // R1: empty and idle after reset.
        check(grant_valid == 1'b0, "R1", int'(grant_valid), 0);
        check(buf_full == 1'b0, "R1", int'(buf_full), 0);

        // R1/R8: first request to a bank is not a hit; slot0 (row 9) stays older winner.
        step(1, 0, 1, 9, 0);
        step(1, 0, 1, 5, 0);
        step(0, 0, 0, 0, 0);
        check(last_idx == 0, "R1", last_idx, 0);

        // R4: one critical (core 1) and one non-critical (core 0) request, sweep threshold.
        do_reset();
        idle_all(); stl[1] = 8; num = 2; thr = 0;
        step(1, 0, 0, 1, 0);
        step(1, 1, 2, 2, 0);
        for (int t = 0; t <= 16; t++) begin
            thr = t;
            step(0, 0, 0, 0, 0);
            check(last_idx == ((t >= 9) ? 1 : 0), "R4", last_idx, (t >= 9) ? 1 : 0);
        end

        // R3: sweep stall count and numerator for core 1, threshold 16.
        thr = 16;
        for (int n = 0; n <= 4; n++)
            for (int s = 0; s <= 8; s++) begin
                int ex;
                num = n; stl[1] = s;
                ex = (s * 4 >= 8 * n && n != 0) ? 1 : 0;
                step(0, 0, 0, 0, 0);
                check(last_idx == ex, "R3", last_idx, ex);
            end

        // R9: after slot 0 is issued and reused, slot 1 is the oldest.
        do_reset();
        idle_all(); num = 2; thr = 0;
        step(1, 0, 3, 10, 0);
        step(1, 0, 4, 11, 0);
        step(1, 0, 5, 12, 0);
        step(0, 0, 0, 0, 1);
        step(1, 0, 6, 13, 0);
        step(0, 0, 0, 0, 0);
        check(last_idx == 1, "R9", last_idx, 1);

        // R8: issuing bank 2 row 5 makes a later request to that row a hit.
        do_reset();
        step(1, 0, 2, 5, 0);
        step(0, 0, 0, 0, 1);
        step(1, 0, 2, 7, 0);
        step(1, 0, 2, 5, 0);
        step(0, 0, 0, 0, 0);
        check(last_idx == 1, "R8", last_idx, 1);

        // R2: fill, one dropped enqueue, then drain exactly 16.
        do_reset();
        for (int k = 0; k < D + 1; k++) step(1, k % C, k % B, k, 0);
        step(0, 0, 0, 0, 0);
        check(buf_full == 1'b1, "R2", int'(buf_full), 1);
        step(1, 3, 3, 99, 1);
        check(model_count() == D - 1, "R2", model_count(), D - 1);
        begin
            int drained = 0;
            for (int k = 0; k < 20; k++) begin
                if (model_count() > 0) drained++;
                step(0, 0, 0, 0, 1);
            end
            check(drained == D - 1, "R2", drained, D - 1);
        end

        // Long sweep: threshold walks 0..16, random counts and traffic.
        do_reset();
        for (int cyc = 0; cyc < 6000; cyc++) begin
            int ep, dp;
            if (cyc % 16 == 0) begin
                for (int c = 0; c < C; c++) begin
                    act[c] = $urandom_range(0, 40);
                    stl[c] = $urandom_range(0, act[c]);
                end
                num = $urandom_range(0, 4);
            end
            thr = (cyc / 200) % 17;
            ep = ((cyc / 500) % 2 == 0) ? 70 : 40;
            dp = ((cyc / 500) % 2 == 0) ? 40 : 70;
            step($urandom_range(0, 99) < ep, $urandom_range(0, C - 1),
                 $urandom_range(0, 3), $urandom_range(0, 3),
                 $urandom_range(0, 99) < dp);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule